// File: doc/BRIEF.md
# Serial Receiver with Break and Framing Detection

This block receives asynchronous serial characters on a single input line. A clock enable running at sixteen times the bit rate drives it. It validates each start bit at mid-bit and takes five to eight data bits, least significant bit first. It samples the stop bit at its centre. Each finished character is written into a small fall-through receive queue with two tags: a framing tag and a break tag.

A break is a character whose data bits are all zero and whose stop bit is low. It produces exactly one queue entry. After that, reception is held off until the line has stayed high for half a bit time. A change-of-break flag is raised when a break starts and again when it ends. A status byte collects sticky error bits and the queue level. Two command strobes clear, separately, the error bits and the change-of-break flag. Parity is not checked.

Top module: `uart_rx_brkdet`

## Requirements
- R1: A start bit must still read low at the middle of the start bit (eight 16x ticks after the falling edge). A low pulse that has ended by then produces no entry and leaves status bit 0 low.
- R2: `char_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data is taken least significant bit first, and the unused upper bits of `rd_data` read zero.
- R3: The stop bit is sampled at its centre. A low stop bit with nonzero data stores an entry with `rd_ferr`=1 and `rd_brk`=0, and sets status bit 6.
- R4: All-zero data with a low stop bit stores exactly one entry: data 0x00, `rd_brk`=1, `rd_ferr`=1. It also sets status bits 7 and 6.
- R5: After a break, no entry is stored until the line has been high for 8 consecutive 16x ticks. A shorter high interval restarts that count.
- R6: `brk_chg` is set when a break is detected. It is set again when the break ends, that is, when the 8-tick marking interval completes.
- R7: If a break starts partway through a character, that character is stored with whatever bits were received, flagged as a framing error. The break itself is reported only after a further full character time of low line.
- R8: The queue holds 8 entries and shows the oldest entry on the read port. `rd_en` removes that entry. Status bit 0 is high when the queue is not empty, and status bit 1 is high when it holds 8 entries.
- R9: A character that completes while the queue is full is discarded and sets status bit 4.
- R10: `cmd_clr_err` clears status bits 7, 6 and 4 and leaves `brk_chg` unchanged. A character completing in the same cycle takes priority.
- R11: `cmd_clr_brk_chg` clears only `brk_chg`. A break start or end in the same cycle takes priority.
- R12: Status bits 5, 3 and 2 always read 0. There is no parity check, and the transmitter bits belong to another block.
- R13: After reset the status byte is 0x00 and `brk_chg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line (high is marking) |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| char_len | input | 2 | Data bits per character, minus 5 |
| cmd_clr_err | input | 1 | Strobe that clears the error status bits |
| cmd_clr_brk_chg | input | 1 | Strobe that clears the change-of-break flag |
| rd_en | input | 1 | Removes the oldest queue entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_brk | output | 1 | Break tag of the oldest entry |
| rd_ferr | output | 1 | Framing tag of the oldest entry |
| status | output | 8 | {break, framing, 0, overrun, 0, 0, full, not empty} |
| brk_chg | output | 1 | Change-of-break flag |

## Verification
The bench builds the block with its default parameters: 16x oversampling, an 8-tick marking interval and an 8-entry queue. It drives `tick16` on every second clock, so each bit lasts 32 clocks. At that rate the mid-bit glitch filter, the marking restart inside a break hold, and a break that begins partway through a character can all be reached with short line patterns. The 8-entry depth lets nine back-to-back characters reach both the full flag and the overrun flag.

// File: rtl/uart_rx_brkdet_pkg.sv
package uart_rx_brkdet_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_STOP, S_HOLD
  } rx_state_t;

  // number of data bits selected by the length code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // a break: every data bit zero and the stop position low
  function automatic logic is_break(input logic [7:0] d, input logic stop);
    return (d == 8'h00) && !stop;
  endfunction

endpackage

// File: rtl/uart_rx_brkdet_sampler.sv
module uart_rx_brkdet_sampler
  import uart_rx_brkdet_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int MARK_TICKS = OVS / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic [1:0] len_code,
  output logic       ev_char_done,
  output logic       ev_brk_start,
  output logic       ev_brk_end,
  output rx_entry_t  char_entry,
  output logic       in_hold
);
  localparam int TW = $clog2(OVS);
  localparam int MW = $clog2(MARK_TICKS + 1);
  localparam logic [TW-1:0] T_MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [MW-1:0] M_LAST = MW'(MARK_TICKS - 1);

  logic [1:0]    sync;
  logic          rx_s;
  rx_state_t     state;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic [MW-1:0] mark;
  logic          last_bit;

  assign rx_s     = sync[1];
  assign in_hold  = (state == S_HOLD);
  assign last_bit = ({1'b0, bidx} == (char_bits(len_code) - 4'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      tcnt         <= '0;
      bidx         <= '0;
      shreg        <= '0;
      mark         <= '0;
      ev_char_done <= 1'b0;
      ev_brk_start <= 1'b0;
      ev_brk_end   <= 1'b0;
      char_entry   <= '0;
    end else begin
      ev_char_done <= 1'b0;
      ev_brk_start <= 1'b0;
      ev_brk_end   <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx_s) begin
              state <= S_START;
              tcnt  <= '0;
            end
          end
          S_START: begin
            if (tcnt == T_MID) begin
              tcnt <= '0;
              if (!rx_s) begin
                state <= S_DATA;
                bidx  <= '0;
                shreg <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_DATA: begin
            if (tcnt == T_LAST) begin
              tcnt        <= '0;
              shreg[bidx] <= rx_s;
              if (last_bit) state <= S_STOP;
              else          bidx  <= bidx + 3'd1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_STOP: begin
            if (tcnt == T_LAST) begin
              tcnt            <= '0;
              ev_char_done    <= 1'b1;
              char_entry.data <= shreg;
              char_entry.ferr <= !rx_s;
              char_entry.brk  <= is_break(shreg, rx_s);
              if (is_break(shreg, rx_s)) begin
                ev_brk_start <= 1'b1;
                state        <= S_HOLD;
                mark         <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_HOLD: begin
            if (rx_s) begin
              if (mark == M_LAST) begin
                ev_brk_end <= 1'b1;
                state      <= S_IDLE;
                mark       <= '0;
              end else begin
                mark <= mark + 1'b1;
              end
            end else begin
              mark <= '0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_brkdet_fifo.sv
module uart_rx_brkdet_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_brkdet_status.sv
module uart_rx_brkdet_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_done,
  input  logic       char_brk,
  input  logic       char_ferr,
  input  logic       q_full,
  input  logic       q_empty,
  input  logic       brk_start,
  input  logic       brk_end,
  input  logic       clr_err,
  input  logic       clr_chg,
  output logic [7:0] status,
  output logic       brk_chg
);
  logic brk_r, ferr_r, ovr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_r   <= 1'b0;
      ferr_r  <= 1'b0;
      ovr_r   <= 1'b0;
      brk_chg <= 1'b0;
    end else begin
      if (clr_err) begin
        brk_r  <= 1'b0;
        ferr_r <= 1'b0;
        ovr_r  <= 1'b0;
      end
      if (char_done) begin
        if (char_brk)  brk_r  <= 1'b1;
        if (char_ferr) ferr_r <= 1'b1;
        if (q_full)    ovr_r  <= 1'b1;
      end
      if (clr_chg)               brk_chg <= 1'b0;
      if (brk_start || brk_end)  brk_chg <= 1'b1;
    end
  end

  assign status = {brk_r, ferr_r, 1'b0, ovr_r, 1'b0, 1'b0, q_full, !q_empty};
endmodule

// File: rtl/uart_rx_brkdet.sv
module uart_rx_brkdet
  import uart_rx_brkdet_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int MARK_TICKS = OVS / 2,
  parameter int DEPTH      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick16,
  input  logic [1:0] char_len,
  input  logic       cmd_clr_err,
  input  logic       cmd_clr_brk_chg,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_ferr,
  output logic [7:0] status,
  output logic       brk_chg
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = $bits(rx_entry_t);

  logic          ev_char_done, ev_brk_start, ev_brk_end, in_hold;
  rx_entry_t     char_entry, head;
  logic [CW-1:0] fifo_count;
  logic          q_full, q_empty;

  uart_rx_brkdet_sampler #(.OVS(OVS), .MARK_TICKS(MARK_TICKS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick16), .len_code(char_len),
    .ev_char_done(ev_char_done), .ev_brk_start(ev_brk_start),
    .ev_brk_end(ev_brk_end), .char_entry(char_entry), .in_hold(in_hold)
  );

  uart_rx_brkdet_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_char_done), .din(char_entry),
    .pop(rd_en), .dout(head), .count(fifo_count)
  );

  assign q_full  = (fifo_count == CW'(DEPTH));
  assign q_empty = (fifo_count == '0);

  uart_rx_brkdet_status u_status (
    .clk(clk), .rst_n(rst_n), .char_done(ev_char_done),
    .char_brk(char_entry.brk), .char_ferr(char_entry.ferr),
    .q_full(q_full), .q_empty(q_empty),
    .brk_start(ev_brk_start), .brk_end(ev_brk_end),
    .clr_err(cmd_clr_err), .clr_chg(cmd_clr_brk_chg),
    .status(status), .brk_chg(brk_chg)
  );

  assign rd_data = head.data;
  assign rd_brk  = head.brk;
  assign rd_ferr = head.ferr;
endmodule

// File: rtl/uart_rx_brkdet_chk.sv
module uart_rx_brkdet_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ev_char_done,
  input logic                       ev_brk_start,
  input logic                       ev_brk_end,
  input logic                       in_hold,
  input logic                       char_brk,
  input logic                       char_ferr,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       cmd_clr_err,
  input logic                       cmd_clr_brk_chg,
  input logic [7:0]                 status,
  input logic                       brk_chg
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_BRK_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk_start |-> (ev_char_done && char_brk && char_ferr)); // R4
  AST_HOLD_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && $past(in_hold)) |-> !ev_char_done); // R5
  AST_END_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk_end |-> $past(in_hold)); // R5
  AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brk_start || ev_brk_end) |=> brk_chg); // R6
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] == (fifo_count == CW'(DEPTH))); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_char_done && fifo_count == CW'(DEPTH)) |=> status[4]); // R9
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_err && !ev_char_done) |=> (status[7:6] == 2'b00 && !status[4])); // R10
  AST_CHG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_brk_chg && !ev_brk_start && !ev_brk_end) |=> !brk_chg); // R11
endmodule

bind uart_rx_brkdet uart_rx_brkdet_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .ev_char_done(ev_char_done),
  .ev_brk_start(ev_brk_start), .ev_brk_end(ev_brk_end), .in_hold(in_hold),
  .char_brk(char_entry.brk), .char_ferr(char_entry.ferr),
  .fifo_count(fifo_count), .cmd_clr_err(cmd_clr_err),
  .cmd_clr_brk_chg(cmd_clr_brk_chg), .status(status), .brk_chg(brk_chg)
);

// File: tb/test_uart_rx_brkdet.sv
`timescale 1ns/1ps
module test_uart_rx_brkdet;
  localparam int BITCLK = 32;  // 16 ticks per bit, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       cmd_clr_err = 1'b0;
  logic       cmd_clr_brk_chg = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data, status;
  logic       rd_brk, rd_ferr, brk_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit settle = 1'b0;
  bit finished = 1'b0;
  int exp_q[$];  // {brk, ferr, data[7:0]}

  always #10 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  uart_rx_brkdet i_uart_rx_brkdet (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .char_len(char_len),
    .cmd_clr_err(cmd_clr_err), .cmd_clr_brk_chg(cmd_clr_brk_chg), .rd_en(rd_en),
    .rd_data(rd_data), .rd_brk(rd_brk), .rd_ferr(rd_ferr),
    .status(status), .brk_chg(brk_chg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model compared on every clock while the line is settled
  always @(negedge clk) begin
    if (settle) begin
      chk("R8 not-empty", int'(status[0]), int'(exp_q.size() != 0));
      chk("R8 full", int'(status[1]), int'(exp_q.size() == 8));
      chk("R12 fixed zeros", int'({status[5], status[3], status[2]}), 0);
    end
  end

  task automatic hold_line(input bit v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_char(input int d, input int nbits, input bit stop);
    settle = 1'b0;
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < nbits; i++) hold_line(d[i], BITCLK);
    if (stop) hold_line(1'b1, BITCLK);
    else begin
      hold_line(1'b0, 22);
      hold_line(1'b1, BITCLK);
    end
  endtask

  task automatic idle(input int clocks);
    rxd = 1'b1;
    repeat (clocks) @(negedge clk);
    settle = 1'b1;
  endtask

  task automatic drain(input string req);
    settle = 1'b0;
    while (exp_q.size() != 0) begin
      int e;
      e = exp_q.pop_front();
      chk({req, " head entry"}, int'({rd_brk, rd_ferr, rd_data}), e);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
    end
    chk({req, " empty after drain"}, int'(status[0]), 0);
    settle = 1'b1;
  endtask

  task automatic pulse(input bit which_err);
    if (which_err) cmd_clr_err = 1'b1; else cmd_clr_brk_chg = 1'b1;
    @(negedge clk);
    cmd_clr_err = 1'b0;
    cmd_clr_brk_chg = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 status", int'(status), 0);
    chk("R13 brk_chg", int'(brk_chg), 0);
    settle = 1'b1;

    // R2 / R8: two 8-bit characters
    send_char(8'hA5, 8, 1'b1); exp_q.push_back(10'h0A5);
    send_char(8'h3C, 8, 1'b1); exp_q.push_back(10'h03C);
    idle(64);
    chk("R3 no framing", int'(status[6]), 0);
    drain("R2 8-bit");

    // R2: 5-bit and 6-bit lengths
    char_len = 2'd0;
    send_char(8'h15, 5, 1'b1); exp_q.push_back(10'h015);
    char_len = 2'd1;
    send_char(8'h2A, 6, 1'b1); exp_q.push_back(10'h02A);
    idle(64);
    drain("R2 short lengths");
    char_len = 2'd3;

    // R1: low glitch shorter than half a bit
    settle = 1'b0;
    hold_line(1'b0, 8);
    idle(400);
    chk("R1 glitch ignored", int'(status[0]), 0);

    // R3: low stop bit with nonzero data
    send_char(8'h81, 8, 1'b0); exp_q.push_back(10'h181);
    idle(64);
    chk("R3 status framing", int'(status[6]), 1);
    chk("R3 status break clear", int'(status[7]), 0);
    drain("R3 framing entry");
    pulse(1'b1);
    chk("R10 framing cleared", int'(status[6]), 0);

    // R4 / R5 / R6: full break
    settle = 1'b0;
    hold_line(1'b0, 10 * BITCLK + 600);
    exp_q.push_back(10'h300);
    settle = 1'b1;
    chk("R4 break status", int'(status[7:6]), 3);
    chk("R6 change on start", int'(brk_chg), 1);
    pulse(1'b0);
    chk("R11 change cleared", int'(brk_chg), 0);
    chk("R11 break status kept", int'(status[7]), 1);
    hold_line(1'b1, 6);
    hold_line(1'b0, 10);
    chk("R5 short mark no end", int'(brk_chg), 0);
    hold_line(1'b1, 40);
    chk("R6 change on end", int'(brk_chg), 1);
    pulse(1'b1);
    chk("R10 break status cleared", int'(status[7]), 0);
    chk("R10 change kept", int'(brk_chg), 1);
    pulse(1'b0);
    drain("R4 R5 single break entry");

    // R7: break beginning mid-character
    settle = 1'b0;
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 4; i++) hold_line(1'b1, BITCLK);
    hold_line(1'b0, 16 * BITCLK);
    exp_q.push_back(10'h10F);
    exp_q.push_back(10'h300);
    idle(100);
    chk("R7 change flag", int'(brk_chg), 1);
    drain("R7 partial then break");
    pulse(1'b0);
    pulse(1'b1);

    // R9: nine characters into an 8-entry queue
    for (int i = 1; i <= 9; i++) begin
      send_char(i, 8, 1'b1);
      if (i <= 8) exp_q.push_back(i);
    end
    idle(64);
    chk("R9 overrun", int'(status[4]), 1);
    chk("R8 full flag", int'(status[1]), 1);
    drain("R9 ninth dropped");
    chk("R9 overrun sticky", int'(status[4]), 1);
    pulse(1'b1);
    chk("R10 overrun cleared", int'(status[4]), 0);

    settle = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule